// File: doc/BRIEF.md
# SPI Register-Access Slave with Burst Addressing

This block is an SPI slave that gives an external SPI master access to a local bank of 128 eight-bit registers. The chip-side logic reaches the same bank through a plain parallel port. The serial pins SCK, MOSI and the active-low chip select are brought into the system clock domain through two-flop synchronizers. SCK edges are then detected there. A mode input pair picks the SCK idle level and which edge samples, so the slave can follow any of the four common clock modes.

Each frame opens with a command byte. Its top bit chooses the direction and its low seven bits give a register index. After that, data bytes flow full-duplex. A write frame stores each complete incoming byte. A read frame streams register contents out on MISO. In both cases the index steps forward after each byte, for as long as chip select stays low, and it wraps at the top of the bank. Raising chip select ends the frame at once and throws away any byte that is not yet complete.

Top module: `spi_regslave`

## Requirements
- R1: After reset, MISO is 0 and every register reads 0 on the parallel port.
- R2: A frame runs only while `csn` is low. Raising `csn` before a byte is complete discards that byte: no register changes, and the next frame starts again with a command byte.
- R3: The first 8 bits after `csn` falls form the command, received MSB first. Bit 7 = 1 means write and bit 7 = 0 means read. Bits 6:0 are the register index.
- R4: In a write frame, the byte right after the command is stored at the indexed register. The store happens only once the 8th bit of that byte has been sampled.
- R5: In a read frame, the indexed register's value is shifted out on MISO, MSB first, during the byte that directly follows the command.
- R6: Each further complete byte in the same frame targets the next index (previous + 1). This holds for writes and for reads.
- R7: The index wraps from 127 to 0.
- R8: `cpol` gives the SCK idle level. When `cpol == cpha` (modes 0 and 3), bits are sampled on SCK rising edges. Otherwise (modes 1 and 2) they are sampled on falling edges. MISO changes only on the opposite edge, or when `csn` goes high.
- R9: MISO is 0 during the command byte, during write data bytes, and while `csn` is high.
- R10: `host_rdata` shows the register selected by `host_addr` combinationally. When `host_we` is high, `host_wdata` is stored at `host_addr` on the next clock edge, and SPI reads return that value afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must run at least 6x the SCK rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpol | input | 1 | SCK idle level; change only while `csn` is high |
| cpha | input | 1 | Clock phase select; change only while `csn` is high |
| sck | input | 1 | Serial clock from the master |
| mosi | input | 1 | Serial data from the master |
| csn | input | 1 | Active-low chip select |
| miso | output | 1 | Serial data to the master |
| host_we | input | 1 | Parallel-port write enable |
| host_addr | input | 7 | Parallel-port register index |
| host_wdata | input | 8 | Parallel-port write data |
| host_rdata | output | 8 | Register contents at `host_addr` |

## Verification
The bench targets these corner cases:

- **Boundary between the command and the first read byte.** A design that fetches the register late, or shifts once too often, would return data rotated by one bit or taken from the wrong index.
- **Bursts across the 127-to-0 boundary.** A design that does not wrap would fail here.
- **All four clock modes.** If the sampling edge is mis-selected, every other bit would be corrupt.
- **Aborted frames.** Chip select is cut in the middle of a data byte and in the middle of a command. A design that commits early, or keeps a stale bit count, would corrupt a register or misframe the following transaction.

// File: rtl/spi_rs_pkg.sv
package spi_rs_pkg;

  // Which part of the frame is being received.
  typedef enum logic {
    PH_ADDR = 1'b0,
    PH_DATA = 1'b1
  } phase_e;

endpackage

// File: rtl/spi_rs_sync.sv
module spi_rs_sync #(
  parameter int              WIDTH   = 1,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/spi_rs_edge.sv
module spi_rs_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_s,
  input  logic cpol,
  input  logic cpha,
  input  logic cs_act,
  output logic smp_pulse,
  output logic shf_pulse
);

  logic sck_d;
  logic rise, fall, late_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_d <= 1'b0;
    else        sck_d <= sck_s;
  end

  assign rise      = sck_s & ~sck_d;
  assign fall      = ~sck_s & sck_d;
  // modes 1 and 2 sample on the falling edge
  assign late_edge = cpol ^ cpha;

  assign smp_pulse = cs_act & (late_edge ? fall : rise);
  assign shf_pulse = cs_act & (late_edge ? rise : fall);

endmodule

// File: rtl/spi_rs_frame.sv
module spi_rs_frame
  import spi_rs_pkg::*;
#(
  parameter int ADDR_W = 7,
  localparam int BYTE_W = ADDR_W + 1,
  localparam int CNT_W  = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              smp_pulse,
  input  logic              shf_pulse,
  input  logic              mosi_s,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [BYTE_W-1:0] wdata_o,
  output logic              miso_o,
  output phase_e            phase_o,
  output logic              wr_mode_o
);

  phase_e            phase_q, phase_d;
  logic              wr_q, wr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-2:0] rx_q, rx_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic [BYTE_W-1:0] tx_q, tx_d;
  logic              miso_q, miso_d;

  logic [BYTE_W-1:0] new_byte;
  logic              byte_done;

  assign new_byte  = {rx_q, mosi_s};
  assign byte_done = smp_pulse && (cnt_q == CNT_W'(BYTE_W - 1));
  // prefetch index: the command's index, or the one after the current
  assign rd_addr_o = (phase_q == PH_ADDR) ? new_byte[ADDR_W-1:0] : ptr_q + 1'b1;

  always_comb begin
    phase_d = phase_q;
    wr_d    = wr_q;
    cnt_d   = cnt_q;
    rx_d    = rx_q;
    ptr_d   = ptr_q;
    tx_d    = tx_q;
    miso_d  = miso_q;
    we_o    = 1'b0;
    if (!cs_act) begin
      phase_d = PH_ADDR;
      wr_d    = 1'b0;
      cnt_d   = '0;
      tx_d    = '0;
      miso_d  = 1'b0;
    end else begin
      if (shf_pulse) begin
        miso_d = tx_q[BYTE_W-1];
        tx_d   = {tx_q[BYTE_W-2:0], 1'b0};
      end
      if (smp_pulse) begin
        rx_d  = new_byte[BYTE_W-2:0];
        cnt_d = cnt_q + 1'b1;
      end
      if (byte_done) begin
        cnt_d = '0;
        if (phase_q == PH_ADDR) begin
          phase_d = PH_DATA;
          wr_d    = new_byte[BYTE_W-1];
          ptr_d   = new_byte[ADDR_W-1:0];
          tx_d    = new_byte[BYTE_W-1] ? '0 : rd_data_i;
        end else if (wr_q) begin
          we_o  = 1'b1;
          ptr_d = ptr_q + 1'b1;
          tx_d  = '0;
        end else begin
          ptr_d = ptr_q + 1'b1;
          tx_d  = rd_data_i;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_ADDR;
      wr_q    <= 1'b0;
      cnt_q   <= '0;
      rx_q    <= '0;
      ptr_q   <= '0;
      tx_q    <= '0;
      miso_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      wr_q    <= wr_d;
      cnt_q   <= cnt_d;
      rx_q    <= rx_d;
      ptr_q   <= ptr_d;
      tx_q    <= tx_d;
      miso_q  <= miso_d;
    end
  end

  assign waddr_o   = ptr_q;
  assign wdata_o   = new_byte;
  assign miso_o    = miso_q;
  assign phase_o   = phase_q;
  assign wr_mode_o = wr_q;

endmodule

// File: rtl/spi_rs_regfile.sv
module spi_rs_regfile #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_waddr,
  input  logic [DATA_W-1:0] a_wdata,
  input  logic [ADDR_W-1:0] a_raddr,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              b_we,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata
);

  logic [DATA_W-1:0] rd_tab [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    logic [DATA_W-1:0] cell_q;
    logic              a_hit, b_hit;

    assign a_hit = a_we && (a_waddr == ADDR_W'(g));
    assign b_hit = b_we && (b_addr == ADDR_W'(g));

    // serial-side write takes precedence over the parallel port
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cell_q <= '0;
      else if (a_hit) cell_q <= a_wdata;
      else if (b_hit) cell_q <= b_wdata;
    end

    assign rd_tab[g] = cell_q;
  end

  assign a_rdata = rd_tab[a_raddr];
  assign b_rdata = rd_tab[b_addr];

endmodule

// File: rtl/spi_regslave.sv
module spi_regslave
  import spi_rs_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2,
  localparam int BYTE_W     = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              sck,
  input  logic              mosi,
  input  logic              csn,
  output logic              miso,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic [BYTE_W-1:0] host_rdata
);

  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic              sck_s, mosi_s, csn_s, cs_act;
  logic              smp_pulse, shf_pulse;
  logic              spi_we;
  logic [ADDR_W-1:0] spi_waddr, spi_raddr;
  logic [BYTE_W-1:0] spi_wdata, spi_rdata;
  phase_e            phase;
  logic              addr_phase, wr_mode;

  // reset asserts asynchronously and releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  spi_rs_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b001)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .d    ({sck, mosi, csn}),
    .q    ({sck_s, mosi_s, csn_s})
  );

  assign cs_act = ~csn_s;

  spi_rs_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .sck_s    (sck_s),
    .cpol     (cpol),
    .cpha     (cpha),
    .cs_act   (cs_act),
    .smp_pulse(smp_pulse),
    .shf_pulse(shf_pulse)
  );

  spi_rs_frame #(.ADDR_W(ADDR_W)) u_frame (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cs_act   (cs_act),
    .smp_pulse(smp_pulse),
    .shf_pulse(shf_pulse),
    .mosi_s   (mosi_s),
    .rd_data_i(spi_rdata),
    .rd_addr_o(spi_raddr),
    .we_o     (spi_we),
    .waddr_o  (spi_waddr),
    .wdata_o  (spi_wdata),
    .miso_o   (miso),
    .phase_o  (phase),
    .wr_mode_o(wr_mode)
  );

  assign addr_phase = (phase == PH_ADDR);

  spi_rs_regfile #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .a_we   (spi_we),
    .a_waddr(spi_waddr),
    .a_wdata(spi_wdata),
    .a_raddr(spi_raddr),
    .a_rdata(spi_rdata),
    .b_we   (host_we),
    .b_addr (host_addr),
    .b_wdata(host_wdata),
    .b_rdata(host_rdata)
  );

endmodule

// File: rtl/spi_regslave_chk.sv
module spi_regslave_chk (
  input logic clk,
  input logic rst_n,
  input logic csn,
  input logic miso,
  input logic cs_act,
  input logic smp_pulse,
  input logic shf_pulse,
  input logic spi_we,
  input logic addr_phase,
  input logic wr_mode
);

  // R4
  commit_on_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_we |-> smp_pulse);

  // R2
  commit_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_we |-> cs_act);

  // R8
  miso_shift_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(miso) |-> ($past(shf_pulse) || $past(!cs_act)));

  // R9
  miso_quiet_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && (addr_phase || wr_mode)) |-> !miso);

  // R9
  miso_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csn && $past(csn) && $past(csn, 2) && $past(csn, 3)) |-> !miso);

endmodule

bind spi_regslave spi_regslave_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .csn       (csn),
  .miso      (miso),
  .cs_act    (cs_act),
  .smp_pulse (smp_pulse),
  .shf_pulse (shf_pulse),
  .spi_we    (spi_we),
  .addr_phase(addr_phase),
  .wr_mode   (wr_mode)
);

// File: tb/spi_regslave_test.sv
module spi_regslave_test;

  localparam int H = 6;   // system clocks per SCK half period

  logic       clk = 1'b0;
  logic       rst_n, cpol, cpha, sck, mosi, csn;
  logic       miso;
  logic       host_we;
  logic [6:0] host_addr;
  logic [7:0] host_wdata, host_rdata;

  logic [7:0] model [128];
  int         n_chk  = 0;
  int         n_fail = 0;

  always #2 clk = ~clk;

  spi_regslave uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpol      (cpol),
    .cpha      (cpha),
    .sck       (sck),
    .mosi      (mosi),
    .csn       (csn),
    .miso      (miso),
    .host_we   (host_we),
    .host_addr (host_addr),
    .host_wdata(host_wdata),
    .host_rdata(host_rdata)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check8(input string req, input string what,
                        input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int i, input int m);
    return 8'((i * 29 + m * 83 + 7) & 255);
  endfunction

  // shifts the nb most significant bits of tx; rx collects MISO MSB first
  task automatic spi_bits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - nb; i--) begin
      if (!cpha) begin
        mosi = tx[i]; tick(H);
        sck = ~cpol; rx[i] = miso; tick(H);
        sck = cpol;
      end else begin
        sck = ~cpol; mosi = tx[i]; tick(H);
        sck = cpol; rx[i] = miso; tick(H);
      end
    end
  endtask

  task automatic cs_open(input int m);
    cpol = m[1]; cpha = m[0]; sck = m[1];
    tick(4); csn = 1'b0; tick(4);
  endtask

  task automatic cs_close();
    tick(4); csn = 1'b1; tick(6);
    check8("R9", "miso idle", {7'd0, miso}, 8'h00);
  endtask

  task automatic burst_write(input int m, input int start, input int n, input int seed);
    logic [7:0] rx;
    cs_open(m);
    spi_bits({1'b1, 7'(start)}, 8, rx);
    check8("R9", "miso in write command", rx, 8'h00);
    for (int i = 0; i < n; i++) begin
      spi_bits(pat(i, seed), 8, rx);
      check8("R9", "miso in write data", rx, 8'h00);
      model[(start + i) & 127] = pat(i, seed);
    end
    cs_close();
  endtask

  task automatic burst_read(input int m, input int start, input int n);
    logic [7:0] rx;
    cs_open(m);
    spi_bits({1'b0, 7'(start)}, 8, rx);
    check8("R9", "miso in read command", rx, 8'h00);
    for (int i = 0; i < n; i++) begin
      spi_bits(8'(i * 7), 8, rx);
      check8("R5 R6 R7 R8", $sformatf("mode %0d read idx %0d", m, (start + i) & 127),
             rx, model[(start + i) & 127]);
    end
    cs_close();
  endtask

  task automatic host_read(input string req, input int a);
    host_addr = 7'(a); #1;
    check8(req, $sformatf("host read idx %0d", a), host_rdata, model[a]);
  endtask

  task automatic host_write(input int a, input logic [7:0] v);
    host_we = 1'b1; host_addr = 7'(a); host_wdata = v;
    tick(1);
    host_we = 1'b0;
    model[a] = v;
  endtask

  initial begin
    logic [7:0] rx;
    rst_n = 1'b0; csn = 1'b1; sck = 1'b0; mosi = 1'b0; cpol = 1'b0; cpha = 1'b0;
    host_we = 1'b0; host_addr = '0; host_wdata = '0;
    for (int a = 0; a < 128; a++) model[a] = 8'h00;
    tick(5); rst_n = 1'b1; tick(6);

    // R1 reset state
    check8("R1", "miso after reset", {7'd0, miso}, 8'h00);
    host_read("R1", 0);
    host_read("R1", 64);
    host_read("R1", 127);

    for (int m = 0; m < 4; m++) begin
      // R4 R6 R7: full-bank burst that wraps past 127
      burst_write(m, (m * 45 + 3) & 127, 128, m);
      for (int a = 0; a < 128; a++) host_read("R4 R6 R7", a);

      // R10: parallel writes seen by serial reads
      for (int k = 0; k < 5; k++) host_write((k * 31 + m) & 127, 8'(8'hA0 + k + m * 16));
      host_read("R10", (m + 31) & 127);
      burst_read(m, (m * 45 + 100) & 127, 130);

      // R3 R7: single-byte write at top index, then read across the wrap
      burst_write(m, 127, 1, m + 9);
      host_read("R3", 127);
      burst_read(m, 127, 2);

      // R2: data byte cut after 5 bits must not commit
      cs_open(m);
      spi_bits({1'b1, 7'(10 + m)}, 8, rx);
      spi_bits(8'h5C ^ 8'(m), 8, rx);
      model[10 + m] = 8'h5C ^ 8'(m);
      spi_bits(8'hFF, 5, rx);
      cs_close();
      host_read("R2 R4", 10 + m);
      host_read("R2", 11 + m);

      // R2: command cut after 4 bits, next frame framed correctly
      cs_open(m);
      spi_bits(8'hF0, 4, rx);
      cs_close();
      burst_read(m, 10 + m, 2);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule